// File: doc/BRIEF.md
# Sliding-Window Row Buffer

This block holds one row of an 8-bit grayscale image in register storage. A pixel stream fills the row one byte per cycle: every cycle with the input valid strobe high stores the byte at the write position, and the write position then moves on by one. The read side presents three horizontally neighbouring pixels as one 24-bit word. This word is the row slice a 3x3 convolution window needs. Each read request moves the read position on by one pixel, so each window shares two pixels with the one before it.

Storage is not consumed on read. The same pixels can be read again as many times as the filter needs. The output word is built combinationally from the current read position, so the three pixels are valid in the same cycle the read request is raised.

The input stream has no back-pressure. The storage can always take a byte, so there is no ready output, and the producer may assert valid on any cycle. Reads and writes use independent positions and may happen in the same cycle.

Top module: `row_window_buf`

## Requirements
- R1: A synchronous active-high reset sets the write and read positions to 0. Stored pixels keep their values through reset.
- R2: On a clock edge with `in_valid` high, `in_pix` is stored at the write position, and the write position then increases by one.
- R3: With `in_valid` low, nothing is stored and the write position holds, whatever value `in_pix` carries.
- R4: `win_out[23:16]` holds the pixel at read position p, `win_out[15:8]` the pixel at p+1, and `win_out[7:0]` the pixel at p+2.
- R5: `win_out` depends combinationally on the read position and the storage. The window for position p is visible during the same cycle that `rd_req` is high at p, with no clock of latency.
- R6: Each clock edge with `rd_req` high moves the read position up by exactly one. With `rd_req` low, the read position holds.
- R7: Both positions run over 0..511 and wrap from 511 to 0. Window addresses are taken modulo 512, so position 510 yields pixels 510, 511 and 0.
- R8: A write and a read may happen in the same cycle, and each position updates independently. A window that covers the address being written shows the old pixel in that cycle and the new pixel after the edge.
- R9: Reading does not alter stored pixels, so a row read twice returns the same data both times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_pix | input | 8 | Pixel byte from the input stream |
| in_valid | input | 1 | Input pixel is valid and is stored on this edge |
| rd_req | input | 1 | Consume the current window and advance the read position |
| win_out | output | 24 | Three adjacent pixels p, p+1, p+2, earliest in the top byte |

## Verification
A stream write and a window read can fall in the same cycle, and may even touch the same address. The bench provokes this by driving `in_valid` and `rd_req` together when both positions point at address 0. It checks that the combinational window still shows the old pixel in that cycle, and that both positions have moved by one after the edge. A reset then brings the read position back to 0 without clearing storage, and the freshly written byte must appear at the top of the window.

// File: rtl/lb_pkg.sv
package lb_pkg;

  localparam int unsigned LB_PIX_W_DEF = 8;
  localparam int unsigned LB_DEPTH_DEF = 512;
  localparam int unsigned LB_TAPS_DEF  = 3;

  // Modular index: base plus offset, folded into 0..depth-1
  function automatic int unsigned lb_wrap(input int unsigned base,
                                          input int unsigned off,
                                          input int unsigned depth);
    int unsigned s;
    s = (base + off) % depth;
    return s;
  endfunction

endpackage

// File: rtl/lb_ptr.sv
module lb_ptr #(
  parameter int unsigned DEPTH = 512,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [AW-1:0] ptr
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (adv) begin
      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(ptr)); // R6
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (adv && ptr != LAST) |=> ptr == $past(ptr) + 1'b1); // R2
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (adv && ptr == LAST) |=> ptr == '0); // R7

endmodule

// File: rtl/lb_store.sv
module lb_store
  import lb_pkg::*;
#(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned DEPTH = 512,
  parameter int unsigned TAPS  = 3,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned OW   = PIX_W * TAPS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [PIX_W-1:0] wr_data,
  input  logic [AW-1:0]    rd_base,
  output logic [OW-1:0]    rd_word
);

  logic [PIX_W-1:0] mem [DEPTH];

  // Write port: storage is never reset, reads never modify it
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  // Read taps: tap 0 (position p) lands in the top byte
  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    logic [AW-1:0] tap_addr;
    assign tap_addr = AW'(lb_wrap(int'(rd_base), k, DEPTH));
    assign rd_word[OW-1-k*PIX_W -: PIX_W] = mem[tap_addr];
  end

  AST_WR_LAND: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> mem[$past(wr_addr)] == $past(wr_data)); // R2

endmodule

// File: rtl/row_window_buf.sv
module row_window_buf
  import lb_pkg::*;
#(
  parameter int unsigned PIX_W = LB_PIX_W_DEF,
  parameter int unsigned DEPTH = LB_DEPTH_DEF,
  parameter int unsigned TAPS  = LB_TAPS_DEF,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned OW   = PIX_W * TAPS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIX_W-1:0] in_pix,
  input  logic             in_valid,
  input  logic             rd_req,
  output logic [OW-1:0]    win_out
);

  logic [AW-1:0] wr_pos;
  logic [AW-1:0] rd_pos;

  lb_ptr #(.DEPTH(DEPTH)) wr_ptr_i (
    .clk (clk),
    .rst (rst),
    .adv (in_valid),
    .ptr (wr_pos)
  );

  lb_ptr #(.DEPTH(DEPTH)) rd_ptr_i (
    .clk (clk),
    .rst (rst),
    .adv (rd_req),
    .ptr (rd_pos)
  );

  lb_store #(.PIX_W(PIX_W), .DEPTH(DEPTH), .TAPS(TAPS)) store_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (in_valid),
    .wr_addr (wr_pos),
    .wr_data (in_pix),
    .rd_base (rd_pos),
    .rd_word (win_out)
  );

  AST_WIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!rd_req && !in_valid) |=> $stable(win_out)); // R6
  AST_WIN_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !in_valid) |=> win_out[OW-1:PIX_W] == $past(win_out[OW-PIX_W-1:0])); // R4

endmodule

// File: tb/row_window_buf_tb_top.sv
module row_window_buf_tb_top;

  localparam int DEPTH = 512;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  in_pix = '0;
  logic        in_valid = 1'b0;
  logic        rd_req = 1'b0;
  logic [23:0] win_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] exp_mem [DEPTH];
  int wp = 0;
  int rp = 0;

  always #2.5 clk = ~clk;

  row_window_buf dut_i (
    .clk      (clk),
    .rst      (rst),
    .in_pix   (in_pix),
    .in_valid (in_valid),
    .rd_req   (rd_req),
    .win_out  (win_out)
  );

  function automatic logic [7:0] pat(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  function automatic logic [23:0] exp_win();
    return {exp_mem[rp], exp_mem[(rp + 1) % DEPTH], exp_mem[(rp + 2) % DEPTH]};
  endfunction

  task automatic check(string req, logic [23:0] expv);
    checks++;
    if (win_out !== expv) begin
      errors++;
      $display("FAIL %s: win_out=%h expected=%h (rp=%0d)", req, win_out, expv, rp);
    end
  endtask

  // Drive inputs mid-cycle, then let combinational output settle
  task automatic drive(bit v, logic [7:0] d, bit r);
    @(negedge clk);
    in_valid = v;
    in_pix   = d;
    rd_req   = r;
    #1;
  endtask

  // Cross the edge and update the bench model
  task automatic commit();
    @(posedge clk);
    if (!rst) begin
      if (in_valid) begin
        exp_mem[wp] = in_pix;
        wp = (wp + 1) % DEPTH;
      end
      if (rd_req) rp = (rp + 1) % DEPTH;
    end else begin
      wp = 0;
      rp = 0;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    drive(0, 8'h00, 0); commit();
    drive(0, 8'h00, 0); commit();
    rst = 1'b0;

    // R2/R3: fill the row, with gaps carrying junk bytes
    begin
      int n = 0;
      int t = 0;
      while (n < DEPTH) begin
        if (t % 5 == 4) begin
          drive(0, 8'hEE, 0);
        end else begin
          drive(1, pat(n), 0);
          n++;
        end
        commit();
        t++;
      end
    end

    // R1 R3 R4: positions started at 0, gaps stored nothing
    drive(0, 8'hEE, 0);
    check("R1", {pat(0), pat(1), pat(2)});
    check("R3", exp_win());

    // R5 R4 R7 R9: read sweep over two full rows
    for (int i = 0; i < 2 * DEPTH; i++) begin
      drive(0, 8'h00, 1);
      if (rp == DEPTH - 2)
        check("R7", {pat(DEPTH - 2), pat(DEPTH - 1), pat(0)});
      else if (i >= DEPTH)
        check("R9", {pat(rp), pat((rp + 1) % DEPTH), pat((rp + 2) % DEPTH)});
      else
        check("R5", exp_win());
      commit();
    end

    // R6: read position holds without rd_req
    for (int i = 0; i < 4; i++) begin
      drive(0, 8'h00, 0);
      check("R6", {pat(0), pat(1), pat(2)});
      commit();
    end

    // R8: write and read the same address in one cycle (both at 0, write wrapped)
    drive(1, 8'h5A, 1);
    check("R8", {pat(0), pat(1), pat(2)});
    commit();
    drive(0, 8'h00, 0);
    check("R8", {pat(1), pat(2), pat(3)});

    // R1 R7: reset returns positions to 0, storage keeps the new byte
    rst = 1'b1;
    commit();
    drive(0, 8'h00, 0);
    rst = 1'b0;
    check("R1", {8'h5A, pat(1), pat(2)});

    // R2: writes at the read position without reads show through the window
    drive(1, 8'hA1, 0); commit();
    drive(1, 8'hA2, 0); commit();
    drive(0, 8'h00, 0);
    check("R2", {8'hA1, 8'hA2, pat(2)});
    drive(1, 8'hA3, 0); commit();
    drive(0, 8'h33, 0); commit();
    drive(0, 8'h00, 0);
    check("R2", {8'hA1, 8'hA2, 8'hA3});
    check("R3", exp_win());

    // R6: a single step of the read position
    drive(0, 8'h00, 1); commit();
    drive(0, 8'h00, 0);
    check("R6", {8'hA2, 8'hA3, pat(3)});

    finish_run();
  end

endmodule